// File: doc/BRIEF.md
# Converter Bus-Interface Controller

This block is the digital front end of a 12-bit successive-approximation converter that sits on a microprocessor bus. It decodes bus strobes into start-of-conversion and read requests. It runs a busy flag for the length of a full-resolution or a short conversion. It also steers the converted result onto twelve output lines, and each line has its own output enable. The conversion engine is represented by a cycle counter. At the end of the count, the counter captures a value that is presented on an input port.

A bus-width strap selects the read format. When the strap is high, all twelve lines are driven at once. When it is low, the result is read as two left-justified bytes on the upper eight lines, and the address bit picks which byte is read. Switching between the two bytes always passes through one cycle with every line released, so the two byte drivers can never overlap.

Top module: `adc_bus_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `busy` is 0, `data_oe` is all zeros and `data_out` is all zeros.
- R2: A start request (`en`=1, `sel_n`=0, `rd_cvt`=0) sampled at a clock edge while idle sets `busy` to 1 from that edge.
- R3: A start taken with `addr0`=0 is a full conversion. `busy` stays high for exactly FULL_CYC cycles. When it falls, the stored result equals `eng_result` as sampled at that edge.
- R4: A start taken with `addr0`=1 is a short conversion. `busy` stays high for exactly SHORT_CYC cycles, and bits 3..0 of the stored result are zero.
- R5: A start request sampled while `busy` is high is ignored. Neither the running conversion's length nor its mode changes.
- R6: A read request (`en`=1, `sel_n`=0, `rd_cvt`=1) sampled at an edge drives the outputs from that edge. With no read request, `data_oe` and `data_out` are all zeros after the edge.
- R7: With `wide`=1, a read sets `data_oe` to 0xFFF and `data_out` to the stored result, whatever the value of `addr0`.
- R8: With `wide`=0, a read enables lines 11..4 only (`data_oe`=0xFF0). With `addr0`=0 those lines carry result bits 11..4. With `addr0`=1 they carry result bits 3..0 on lines 11..8 and zeros on lines 7..4.
- R9: If `addr0` changes during a byte-mode read, the next cycle has `data_oe` all zeros, and the new byte is driven in the cycle after that. The two byte selections are never driven in adjacent cycles.
- R10: A read made while a conversion is running returns the result of the previous conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Chip enable, active high |
| sel_n | input | 1 | Chip select, active low |
| rd_cvt | input | 1 | 1 = read, 0 = start conversion |
| addr0 | input | 1 | Byte select on reads; short-conversion select on starts |
| wide | input | 1 | Bus-width strap: 1 = 12-bit parallel, 0 = two bytes |
| eng_result | input | 12 | Value produced by the conversion engine |
| busy | output | 1 | Conversion in progress |
| data_out | output | 12 | Output data lines |
| data_oe | output | 12 | Per-line output enable |

## Verification
Some properties are checked by assertions on every cycle. A start taken while idle raises `busy`. `busy` holds while the count is non-zero. A start request made during a conversion leaves its mode unchanged. A short result has a zero low nibble when `busy` falls. One byte selection never directly follows the other. A missing read request empties the enables. Other properties can only be shown by the bench's scenarios. These are the exact conversion lengths counted from the outside, the byte contents under each strap and address setting, the single released cycle when the address changes in the middle of a read, and a read during a conversion returning the previous result.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_WIDE = 2'd1,
    SEL_HI   = 2'd2,
    SEL_LO   = 2'd3
  } out_sel_e;
endpackage

// File: rtl/adc_cmd_decode.sv
module adc_cmd_decode (
  input  logic en,
  input  logic sel_n,
  input  logic rd_cvt,
  output logic start_req,
  output logic read_req
);
  logic active;
  always_comb begin
    active    = en && !sel_n;
    start_req = active && !rd_cvt;
    read_req  = active && rd_cvt;
  end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int DATA_W    = 12,
  parameter int LOW_W     = 4,
  parameter int FULL_CYC  = 600,
  parameter int SHORT_CYC = 400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_req,
  input  logic              addr0,
  input  logic [DATA_W-1:0] eng_result,
  output logic              busy,
  output logic [DATA_W-1:0] result
);
  localparam int CNT_W = (FULL_CYC > 1) ? $clog2(FULL_CYC) : 1;
  localparam logic [CNT_W-1:0] FULL_LD  = CNT_W'(FULL_CYC - 1);
  localparam logic [CNT_W-1:0] SHORT_LD = CNT_W'(SHORT_CYC - 1);
  localparam logic [DATA_W-1:0] SHORT_MASK = {{(DATA_W-LOW_W){1'b1}}, {LOW_W{1'b0}}};

  logic [CNT_W-1:0] cnt;
  logic             short_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      cnt     <= '0;
      short_q <= 1'b0;
      result  <= '0;
    end else if (!busy) begin
      if (start_req) begin
        busy    <= 1'b1;
        short_q <= addr0;
        cnt     <= addr0 ? SHORT_LD : FULL_LD;
      end
    end else if (cnt == '0) begin
      busy   <= 1'b0;
      result <= short_q ? (eng_result & SHORT_MASK) : eng_result;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  // R2
  start_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (start_req && !busy) |=> busy);
  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt != '0) |=> busy);
  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL_LD);
  // R4
  short_nibble_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && short_q) |-> (result[LOW_W-1:0] == '0));
  // R5
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start_req) |=> $stable(short_q));
endmodule

// File: rtl/adc_out_steer.sv
module adc_out_steer
  import adc_bus_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              read_req,
  input  logic              wide,
  input  logic              addr0,
  input  logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] data_out,
  output logic [DATA_W-1:0] data_oe
);
  localparam int LOW_W = DATA_W - BYTE_W;
  localparam logic [DATA_W-1:0] BYTE_OE = {{BYTE_W{1'b1}}, {LOW_W{1'b0}}};

  out_sel_e sel_q, want, sel_d;
  logic [BYTE_W-1:0] hi_byte, lo_byte;

  always_comb begin
    hi_byte = result[DATA_W-1 -: BYTE_W];
    lo_byte = {result[LOW_W-1:0], {(BYTE_W-LOW_W){1'b0}}};
    if (!read_req)  want = SEL_NONE;
    else if (wide)  want = SEL_WIDE;
    else if (addr0) want = SEL_LO;
    else            want = SEL_HI;
    if (want == SEL_NONE || sel_q == SEL_NONE || sel_q == want) sel_d = want;
    else sel_d = SEL_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= SEL_NONE;
      data_out <= '0;
      data_oe  <= '0;
    end else begin
      sel_q <= sel_d;
      case (sel_d)
        SEL_WIDE: begin data_out <= result;                    data_oe <= '1;      end
        SEL_HI:   begin data_out <= {hi_byte, {LOW_W{1'b0}}};  data_oe <= BYTE_OE; end
        SEL_LO:   begin data_out <= {lo_byte, {LOW_W{1'b0}}};  data_oe <= BYTE_OE; end
        default:  begin data_out <= '0;                        data_oe <= '0;      end
      endcase
    end
  end

  // R9
  hi_to_lo_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_q == SEL_HI) |=> (sel_q != SEL_LO));
  // R9
  lo_to_hi_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_q == SEL_LO) |=> (sel_q != SEL_HI));
  // R6
  float_chk: assert property (@(posedge clk) disable iff (rst)
    !read_req |=> (data_oe == '0 && data_out == '0));
endmodule

// File: rtl/adc_bus_ctrl.sv
module adc_bus_ctrl #(
  parameter int DATA_W    = 12,
  parameter int BYTE_W    = 8,
  parameter int FULL_CYC  = 600,
  parameter int SHORT_CYC = 400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              sel_n,
  input  logic              rd_cvt,
  input  logic              addr0,
  input  logic              wide,
  input  logic [DATA_W-1:0] eng_result,
  output logic              busy,
  output logic [DATA_W-1:0] data_out,
  output logic [DATA_W-1:0] data_oe
);
  localparam int LOW_W = DATA_W - BYTE_W;

  logic start_req, read_req;
  logic [DATA_W-1:0] result;

  adc_cmd_decode i_dec (
    .en(en), .sel_n(sel_n), .rd_cvt(rd_cvt),
    .start_req(start_req), .read_req(read_req)
  );

  adc_conv_seq #(
    .DATA_W(DATA_W), .LOW_W(LOW_W), .FULL_CYC(FULL_CYC), .SHORT_CYC(SHORT_CYC)
  ) i_seq (
    .clk(clk), .rst(rst), .start_req(start_req), .addr0(addr0),
    .eng_result(eng_result), .busy(busy), .result(result)
  );

  adc_out_steer #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) i_steer (
    .clk(clk), .rst(rst), .read_req(read_req), .wide(wide), .addr0(addr0),
    .result(result), .data_out(data_out), .data_oe(data_oe)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!busy && data_oe == '0 && data_out == '0));
endmodule

// File: tb/test_adc_bus_ctrl.sv
module test_adc_bus_ctrl;
  localparam int FULL  = 600;
  localparam int SHORT = 400;

  logic clk = 1'b0, rst = 1'b1;
  logic en = 0, sel_n = 1, rd_cvt = 1, addr0 = 0, wide = 1;
  logic [11:0] eng_result = '0;
  logic busy;
  logic [11:0] data_out, data_oe;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  adc_bus_ctrl #(.FULL_CYC(FULL), .SHORT_CYC(SHORT)) i_adc_bus_ctrl (
    .clk(clk), .rst(rst), .en(en), .sel_n(sel_n), .rd_cvt(rd_cvt),
    .addr0(addr0), .wide(wide), .eng_result(eng_result),
    .busy(busy), .data_out(data_out), .data_oe(data_oe)
  );

  // {wide, en, sel_n, rd_cvt, addr0, exp_oe, exp_data}; stored result 0xA5C
  localparam logic [28:0] VEC [7] = '{
    {5'b11010, 12'hFFF, 12'hA5C},
    {5'b11011, 12'hFFF, 12'hA5C},
    {5'b01010, 12'hFF0, 12'hA50},
    {5'b01011, 12'hFF0, 12'hC00},
    {5'b10010, 12'h000, 12'h000},
    {5'b11110, 12'h000, 12'h000},
    {5'b00011, 12'h000, 12'h000}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    en = 0; sel_n = 1; rd_cvt = 1;
  endtask

  task automatic start_conv(input bit short_sel);
    @(negedge clk);
    en = 1; sel_n = 0; rd_cvt = 0; addr0 = short_sel;
    @(negedge clk);
    idle();
  endtask

  // counts negedges with busy high, first one already sampled by caller
  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic read_wide(output logic [11:0] d, output logic [11:0] oe);
    @(negedge clk);
    wide = 1; en = 1; sel_n = 0; rd_cvt = 1;
    @(negedge clk);
    d = data_out; oe = data_oe;
    idle();
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    logic [11:0] d, oe;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(!busy && data_oe == 0 && data_out == 0, "R1", {busy, data_oe}, 0);
    rst = 0;
    @(negedge clk);
    check(!busy && data_oe == 0 && data_out == 0, "R1", {busy, data_oe}, 0);

    // full conversion, engine value 0xA5C
    eng_result = 12'hA5C;
    start_conv(1'b0);
    check(busy, "R2", busy, 1);
    // R10: read while busy returns previous (reset) result
    @(negedge clk);
    wide = 1; en = 1; sel_n = 0; rd_cvt = 1;
    @(negedge clk);
    check(data_out == 12'h000 && data_oe == 12'hFFF, "R10", data_out, 0);
    // R5: short start while busy must be ignored
    en = 1; sel_n = 0; rd_cvt = 0; addr0 = 1;
    @(negedge clk);
    idle();
    n = 3;
    begin
      int rest;
      count_busy(rest);
      n += rest;
    end
    check(n == FULL, "R3", n, FULL);
    check(n == FULL, "R5", n, FULL);

    // table walk
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      {wide, en, sel_n, rd_cvt, addr0} = VEC[i][28:24];
      @(negedge clk);
      if (i < 2)
        check(data_oe == VEC[i][23:12] && data_out == VEC[i][11:0], "R7", data_out, VEC[i][11:0]);
      else if (i < 4)
        check(data_oe == VEC[i][23:12] && data_out == VEC[i][11:0], "R8", data_out, VEC[i][11:0]);
      else
        check(data_oe == VEC[i][23:12] && data_out == VEC[i][11:0], "R6", data_oe, VEC[i][23:12]);
      idle();
    end
    check(data_oe == 0, "R3", data_out, 12'hA5C);

    // R9 break-before-make on addr0 change mid-read
    @(negedge clk);
    wide = 0; en = 1; sel_n = 0; rd_cvt = 1; addr0 = 0;
    @(negedge clk);
    check(data_oe == 12'hFF0 && data_out == 12'hA50, "R9", data_out, 12'hA50);
    addr0 = 1;
    @(negedge clk);
    check(data_oe == 12'h000, "R9", data_oe, 0);
    @(negedge clk);
    check(data_oe == 12'hFF0 && data_out == 12'hC00, "R9", data_out, 12'hC00);
    addr0 = 0;
    @(negedge clk);
    check(data_oe == 12'h000, "R9", data_oe, 0);
    @(negedge clk);
    check(data_out == 12'hA50, "R9", data_out, 12'hA50);
    check(!busy, "R9", busy, 0);
    idle();

    // short conversion
    eng_result = 12'h3C7;
    start_conv(1'b1);
    count_busy(n);
    check(n == SHORT, "R4", n, SHORT);
    read_wide(d, oe);
    check(d == 12'h3C0 && oe == 12'hFFF, "R4", d, 12'h3C0);

    // R10 again: full conversion running, read returns short result
    eng_result = 12'h123;
    start_conv(1'b0);
    read_wide(d, oe);
    check(d == 12'h3C0, "R10", d, 12'h3C0);
    begin
      int rest;
      count_busy(rest);
      check(rest == FULL - 2, "R3", rest, FULL - 2);
    end
    read_wide(d, oe);
    check(d == 12'h123, "R3", d, 12'h123);

    // R1 reset clears outputs mid-read
    @(negedge clk);
    en = 1; sel_n = 0; rd_cvt = 1;
    rst = 1;
    @(negedge clk);
    check(data_oe == 0 && !busy, "R1", data_oe, 0);
    rst = 0; idle();
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule